// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-programmed master that performs one serial-flash transaction each time software launches it. Software fills in a command byte and a 24-bit flash address, optionally places up to four payload bytes in a data word, and writes a control word that carries the transmit and receive byte counts together with a launch bit. The engine then lowers chip select, clocks out the requested bytes in SPI mode 0, collects any reply bytes into the data word, and raises chip select again. A busy flag in the control word tells software when the result is ready and when the registers may be touched again.

The register port is a plain single-cycle interface. It never stalls, so it has no back-pressure: a write is taken on the clock edge on which `reg_wr_en` is high, and `reg_rdata` follows `reg_word` in the same cycle. The serial side has no handshake either. Its pace is set only by the divider that software selects. Typical use is to write the address word and then the data word, write the control word with the launch bit set, and poll busy until it reads zero.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, all three registers read zero, chip select is high (inactive), and SCK and MOSI are low.
- R2: Control word (word 0) layout. Bits 3:0 hold the transmit count, bits 7:4 the receive count, bits 18:17 a stored size field and bits 25:24 the clock select. These fields read back as written. Bit 16 reads as busy. Bit 8 (launch) and every other bit read as zero.
- R3: A control write that has bit 8 set, has a non-zero total count and arrives while busy is low starts a transaction. Busy reads one and chip select stays low from that edge until the final bit. Busy then clears on the same edge on which chip select rises. A launch with both counts zero, or a launch while busy, does nothing.
- R4: Transmit bytes go out MSB first in this order: the command byte from bits 7:0 of word 1; address bits 23:16, 15:8 and 7:0 (word 1 bits 31:24, 23:16, 15:8); then payload bytes from word 2 starting at bits 7:0. A transmit count above 8 acts as 8.
- R5: Receive bytes follow the transmit bytes directly, with MOSI held low. The first byte received lands in bits 7:0 of word 2, the next in 15:8, and so on, with the unused upper bytes cleared. A receive count above 4 acts as 4, and a count of zero leaves word 2 unchanged.
- R6: The serial interface uses SPI mode 0. SCK idles low and pulses only while chip select is low. MOSI changes only while SCK is low, and MISO is sampled on the rising edge of SCK.
- R7: Clock select k (0 to 3) gives an SCK period of 2^(k+1) system clocks. One SCK pulse is issued per bit, and chip select stays low for exactly bits × 2^(k+1) clocks.
- R8: While busy is high, writes to any of the three words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_word | input | 2 | Word index: 0 control, 1 command/address, 2 data, 3 unmapped |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Each fault class shows up on the serial pins at a predictable point:
- A wrong bit counter or wrong latched byte count appears within one transaction, as an SCK pulse count or chip-select low time that differs from the programmed counts. The bench counts both exactly.
- Faults in the byte selection or in the packing of the reply word appear as soon as the first wrong byte has been shifted, on MOSI or in word 2 when it is read back after busy falls.
- Faults in the divider or in the launch qualification change the chip-select duration, or start or drop a frame on the very edge of the offending write.

// File: rtl/spi_eng_pkg.sv
`timescale 1ns/1ps
package spi_eng_pkg;
  localparam int REG_W      = 32;
  localparam int CNT_W      = 4;
  localparam int SEL_W      = 2;
  localparam int SIZE_W     = 2;
  localparam int ADDR_BYTES = 3;
  localparam int RXN_MAX    = REG_W / 8;
  localparam int TXN_MAX    = 1 + ADDR_BYTES + RXN_MAX;

  localparam int TXC_LSB   = 0;
  localparam int RXC_LSB   = 4;
  localparam int START_BIT = 8;
  localparam int BUSY_BIT  = 16;
  localparam int SIZE_LSB  = 17;
  localparam int CLK_LSB   = 24;

  localparam logic [REG_W-1:0] CTRL_RW_MASK =
      (REG_W'((1 << CNT_W) - 1) << TXC_LSB) |
      (REG_W'((1 << CNT_W) - 1) << RXC_LSB) |
      (REG_W'((1 << SIZE_W) - 1) << SIZE_LSB) |
      (REG_W'((1 << SEL_W) - 1) << CLK_LSB);

  typedef enum logic [1:0] {
    WSEL_CTRL = 2'd0,
    WSEL_OPC  = 2'd1,
    WSEL_DATA = 2'd2,
    WSEL_NONE = 2'd3
  } word_sel_e;
endpackage

// File: rtl/spi_eng_clkdiv.sv
`timescale 1ns/1ps
module spi_eng_clkdiv #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int HCNT_W = ((1 << SEL_W) - 1) > 0 ? ((1 << SEL_W) - 1) : 1;

  generate
    if (SEL_W == 0) begin : g_nodiv
      assign tick = run;
    end else begin : g_div
      logic [HCNT_W-1:0] hcnt;
      logic [HCNT_W-1:0] half_m1;

      always_comb half_m1 = HCNT_W'((1 << sel) - 1);
      assign tick = run && (hcnt == half_m1);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             hcnt <= '0;
        else if (!run || tick)  hcnt <= '0;
        else                    hcnt <= hcnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/spi_eng_regs.sv
`timescale 1ns/1ps
module spi_eng_regs
  import spi_eng_pkg::*;
#(
  parameter int RW  = REG_W,
  parameter int CW  = CNT_W,
  parameter int SW  = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  word_sel_e     wsel,
  input  logic [RW-1:0] wdata,
  input  logic          busy,
  input  logic          rx_load,
  input  logic [RW-1:0] rx_word,
  output logic [RW-1:0] opc_q,
  output logic [RW-1:0] data_q,
  output logic [SW-1:0] clk_sel,
  output logic          launch,
  output logic [CW-1:0] launch_tx,
  output logic [CW-1:0] launch_rx,
  output logic [RW-1:0] rdata
);
  logic [RW-1:0] ctrl_q;
  logic          wr_ok;

  assign wr_ok     = wr_en && !busy;
  assign launch_tx = wdata[TXC_LSB +: CW];
  assign launch_rx = wdata[RXC_LSB +: CW];
  assign launch    = wr_ok && (wsel == WSEL_CTRL) && wdata[START_BIT] &&
                     ((launch_tx != '0) || (launch_rx != '0));
  assign clk_sel   = ctrl_q[CLK_LSB +: SW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      opc_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_ok && wsel == WSEL_CTRL) ctrl_q <= wdata & CTRL_RW_MASK;
      if (wr_ok && wsel == WSEL_OPC)  opc_q  <= wdata;
      if (rx_load)                    data_q <= rx_word;
      else if (wr_ok && wsel == WSEL_DATA) data_q <= wdata;
    end
  end

  always_comb begin
    unique case (wsel)
      WSEL_CTRL: rdata = ctrl_q | (RW'(busy) << BUSY_BIT);
      WSEL_OPC:  rdata = opc_q;
      WSEL_DATA: rdata = data_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_eng_shifter.sv
`timescale 1ns/1ps
module spi_eng_shifter
  import spi_eng_pkg::*;
#(
  parameter int RW    = REG_W,
  parameter int CW    = CNT_W,
  parameter int ABYT  = ADDR_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [CW-1:0] launch_tx,
  input  logic [CW-1:0] launch_rx,
  input  logic          tick,
  input  logic [RW-1:0] opc,
  input  logic [RW-1:0] dat,
  input  logic          miso,
  output logic          busy,
  output logic          cs_n,
  output logic          sck,
  output logic          mosi,
  output logic          rx_load,
  output logic [RW-1:0] rx_word
);
  localparam int RXMAX    = RW / 8;
  localparam int TXMAX    = 1 + ABYT + RXMAX;
  localparam int BIT_W    = $clog2((TXMAX + RXMAX) * 8);
  localparam int TW       = BIT_W + 1;
  localparam int BYTE_W   = BIT_W - 3;
  localparam int RXI_W    = $clog2(RXMAX * 8);

  logic [BIT_W-1:0]  bit_idx, nxt_idx;
  logic [CW-1:0]     tx_n, rx_n, tx_eff, rx_eff, nxt_tx;
  logic [TW-1:0]     tx_bits, total_bits;
  logic              last_bit, in_rx, nxt_bit;
  logic [RXI_W-1:0]  rx_off;
  logic [7:0]        nxt_byte;

  function automatic logic [7:0] pick_byte(input int b, input logic [RW-1:0] o,
                                           input logic [RW-1:0] d);
    if (b == 0)             return o[7:0];
    else if (b <= ABYT)     return o[RW - 8*b +: 8];
    else if (b < TXMAX)     return d[8*(b - ABYT - 1) +: 8];
    else                    return 8'h00;
  endfunction

  assign tx_eff = (launch_tx > CW'(TXMAX)) ? CW'(TXMAX) : launch_tx;
  assign rx_eff = (launch_rx > CW'(RXMAX)) ? CW'(RXMAX) : launch_rx;

  always_comb begin
    nxt_idx  = launch ? '0 : bit_idx + 1'b1;
    nxt_tx   = launch ? tx_eff : tx_n;
    nxt_byte = pick_byte(int'(nxt_idx[BIT_W-1:3]), opc, dat);
    nxt_bit  = (TW'(nxt_idx[BIT_W-1:3]) < TW'(nxt_tx)) ? nxt_byte[~nxt_idx[2:0]] : 1'b0;
  end

  assign tx_bits    = TW'(tx_n) << 3;
  assign total_bits = (TW'(tx_n) + TW'(rx_n)) << 3;
  assign last_bit   = (TW'(bit_idx) == total_bits - 1'b1);
  assign in_rx      = (TW'(bit_idx) >= tx_bits);
  assign rx_off     = RXI_W'(TW'(bit_idx) - tx_bits);
  assign rx_load    = busy && tick && sck && last_bit && (rx_n != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cs_n    <= 1'b1;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      bit_idx <= '0;
      tx_n    <= '0;
      rx_n    <= '0;
      rx_word <= '0;
    end else if (launch) begin
      busy    <= 1'b1;
      cs_n    <= 1'b0;
      sck     <= 1'b0;
      bit_idx <= '0;
      tx_n    <= tx_eff;
      rx_n    <= rx_eff;
      mosi    <= nxt_bit;
      rx_word <= '0;
    end else if (busy && tick) begin
      if (!sck) begin
        sck <= 1'b1;
        if (in_rx) rx_word[{rx_off[RXI_W-1:3], ~rx_off[2:0]}] <= miso;
      end else begin
        sck <= 1'b0;
        if (last_bit) begin
          busy <= 1'b0;
          cs_n <= 1'b1;
          mosi <= 1'b0;
        end else begin
          bit_idx <= nxt_idx;
          mosi    <= nxt_bit;
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int CW = CNT_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [1:0]    reg_word,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          spi_sck,
  output logic          spi_cs_n,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  word_sel_e     wsel;
  logic          busy, launch, tick, rx_load;
  logic [CW-1:0] launch_tx, launch_rx;
  logic [SW-1:0] clk_sel;
  logic [RW-1:0] opc_q, data_q, rx_word;

  assign wsel = word_sel_e'(reg_word);

  spi_eng_regs #(.RW(RW), .CW(CW), .SW(SW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wsel(wsel), .wdata(reg_wdata),
    .busy(busy), .rx_load(rx_load), .rx_word(rx_word), .opc_q(opc_q),
    .data_q(data_q), .clk_sel(clk_sel), .launch(launch), .launch_tx(launch_tx),
    .launch_rx(launch_rx), .rdata(reg_rdata)
  );

  spi_eng_clkdiv #(.SEL_W(SW)) div_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .sel(clk_sel), .tick(tick)
  );

  spi_eng_shifter #(.RW(RW), .CW(CW), .ABYT(ADDR_BYTES)) shf_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_tx(launch_tx),
    .launch_rx(launch_rx), .tick(tick), .opc(opc_q), .dat(data_q),
    .miso(spi_miso), .busy(busy), .cs_n(spi_cs_n), .sck(spi_sck),
    .mosi(spi_mosi), .rx_load(rx_load), .rx_word(rx_word)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
`timescale 1ns/1ps
module spi_cmd_engine_chk #(
  parameter int RW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    word,
  input logic          wr_start,
  input logic          sck,
  input logic          cs_n,
  input logic          mosi,
  input logic          busy,
  input logic [RW-1:0] opc_q
);
  assert_sck_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);

  assert_mosi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  assert_frame_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n);

  assert_launch_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && word == 2'd0 && wr_start));

  assert_opc_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && word == 2'd1) |=> $stable(opc_q));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.RW(RW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .word(reg_word),
  .wr_start(reg_wdata[8]), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
  .busy(busy), .opc_q(opc_q)
);

// File: tb/spi_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  word = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sck, cs_n, mosi;
  logic        miso;

  always #5 clk = ~clk;

  spi_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_word(word),
    .reg_wdata(wdata), .reg_rdata(rdata), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  int          errors = 0;
  int          checks = 0;
  int          cyc = 0;
  int          nrise = 0;
  int          cslow = 0;
  int          tx_bits_m = 0;
  logic [127:0] cap;
  logic [31:0] rx_pat = '0;

  always @(posedge clk) cyc++;
  always @(negedge clk) if (!cs_n) cslow++;

  always @(posedge sck) begin
    if (nrise < 128) cap[nrise] = mosi;
    nrise++;
  end

  always @(negedge sck or negedge cs_n) begin
    int k;
    k = nrise - tx_bits_m;
    miso <= (k >= 0 && k < 32) ? rx_pat[(k / 8) * 8 + 7 - (k % 8)] : 1'b0;
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] w, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; word = w; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] w, output logic [31:0] d);
    @(negedge clk);
    word = w;
    #1 d = rdata;
  endtask

  function automatic logic [7:0] exp_byte(input int i, input logic [31:0] op,
                                          input logic [31:0] dat);
    if (i == 0) return op[7:0];
    if (i <= 3) return op[32 - 8*i +: 8];
    return dat[8*(i-4) +: 8];
  endfunction

  task automatic run_txn(input logic [31:0] op, input logic [31:0] dat,
                         input int tx, input int rx, input int sel, input bit meddle);
    int te, re, nb, bad_i, hold;
    logic [31:0] v, mask, exp_d;
    logic [7:0] got, expb;
    bit ok, low_ok;
    te = (tx > 8) ? 8 : tx;
    re = (rx > 4) ? 4 : rx;
    nb = (te + re) * 8;
    wr(2'd1, op);
    wr(2'd2, dat);
    rx_pat = $urandom;
    tx_bits_m = te * 8;
    nrise = 0; cslow = 0; cap = '0;
    wr(2'd0, (32'(sel) << 24) | 32'h100 | (32'(rx) << 4) | 32'(tx));
    if (meddle) begin
      repeat (20) @(negedge clk);
      wr(2'd1, ~op);
      wr(2'd2, ~dat);
      wr(2'd0, 32'h0000_0111);
    end
    hold = 0;
    v = 32'h1_0000;
    while (v[16] && hold < 5000) begin rd(2'd0, v); hold++; end
    check("R3", "busy cleared", 64'(v[16]), 64'd0);
    check("R3", "cs released", 64'(cs_n), 64'd1);
    check("R2", "ctrl readback", 64'(v),
          64'((32'(sel) << 24) | (32'(rx) << 4) | 32'(tx)));
    check("R6", "sck idle", 64'(sck), 64'd0);
    check("R7", "sck pulses", 64'(nrise), 64'(nb));
    check("R7", "cs low cycles", 64'(cslow), 64'(nb * (2 << sel)));
    ok = 1'b1; bad_i = 0; got = '0; expb = '0;
    for (int i = 0; i < te; i++) begin
      logic [7:0] g;
      for (int b = 0; b < 8; b++) g[7-b] = cap[i*8+b];
      if (ok && g !== exp_byte(i, op, dat)) begin
        ok = 1'b0; bad_i = i; got = g; expb = exp_byte(i, op, dat);
      end
    end
    check("R4", $sformatf("tx byte %0d", bad_i), 64'(got), 64'(expb));
    low_ok = 1'b1;
    for (int i = te*8; i < nb; i++) if (cap[i] !== 1'b0) low_ok = 1'b0;
    check("R5", "mosi low in rx", 64'(low_ok), 64'd1);
    mask = (re == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*re)) - 1);
    exp_d = (re == 0) ? dat : (rx_pat & mask);
    rd(2'd2, v);
    check(meddle ? "R8" : "R5", "data word", 64'(v), 64'(exp_d));
    if (meddle) begin
      rd(2'd1, v);
      check("R8", "opcode kept", 64'(v), 64'(op));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3 watchdog expired actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, v); check("R1", "ctrl reset", 64'(v), 64'd0);
    rd(2'd1, v); check("R1", "opc reset", 64'(v), 64'd0);
    rd(2'd2, v); check("R1", "data reset", 64'(v), 64'd0);
    check("R1", "pins idle", 64'({cs_n, sck, mosi}), 64'b100);

    wr(2'd0, 32'hFFFF_FEFF);
    rd(2'd0, v); check("R2", "field readback", 64'(v), 64'h0306_00FF);
    check("R3", "no launch without bit 8", 64'(cs_n), 64'd1);
    rd(2'd3, v); check("R2", "unmapped word", 64'(v), 64'd0);

    wr(2'd0, 32'h0000_0100);
    rd(2'd0, v); check("R3", "zero-count launch busy", 64'(v[16]), 64'd0);
    check("R3", "zero-count launch cs", 64'(cs_n), 64'd1);

    run_txn(32'h0000_00AB, 32'h5A5A_5A5A, 4, 1, 0, 1'b0);
    run_txn(32'h1234_5602, 32'h4433_2211, 8, 0, 1, 1'b0);
    run_txn(32'hA1B2_C303, 32'h0BAD_F00D, 12, 7, 0, 1'b0);
    run_txn(32'h0000_0005, 32'hCAFE_0000, 0, 2, 2, 1'b0);
    run_txn(32'h00FF_EED8, 32'h1357_9BDF, 4, 0, 3, 1'b1);

    for (int n = 0; n < 16; n++) begin
      int tx, rx;
      tx = $urandom_range(0, 10);
      rx = $urandom_range(0, 6);
      if (tx == 0 && rx == 0) tx = 1;
      run_txn($urandom, $urandom, tx, rx, $urandom_range(0, 3), 1'b0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule